// File: doc/BRIEF.md
# Multi-Mode Address Generation Unit

This unit forms the effective data address for a load/store pipeline. Each request carries a mode code, one or two register values, a 16-bit signed displacement, a two-bit element-size code, a circular-buffer window and a bit-reverse width. One cycle after the request is accepted, the unit presents the address. For the auto-modify modes it also presents a value that the pipeline writes back into the pointer register.

Besides the general modes (displacement, register-indirect, indexed, absolute, scaled, post-increment and pre-decrement), the unit offers two signal-processing modes. The first steps a pointer through a modulo buffer. The second adds a bit-reversed index to a base, which serves FFT data reordering. In memory-indirect mode the unit first fetches a pointer through an external read port with a request/acknowledge pair. It accepts no new request until that read is acknowledged.

Top module: `agu_top`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `wb_en` and `ptr_rd_req` are low and `req_ready` is low. `req_ready` rises on the second rising clock edge after `rst_n` goes high.
- R2: Mode 0 (displacement) gives `base_val` plus the sign-extended `disp`. Mode 1 (register-indirect) gives `base_val`.
- R3: Mode 2 (indexed) gives `base_val + index_val`. Mode 3 (absolute) gives the sign-extended `disp`.
- R4: Mode 4 (post-increment) gives `base_val` as the address, with `wb_en` high and `wb_val = base_val + d`. Here d = 1 << `elem_sz`, so codes 0..3 give 1, 2, 4 and 8.
- R5: Mode 5 (pre-decrement) gives `base_val - d` as both the address and `wb_val`, with `wb_en` high.
- R6: Mode 6 (scaled) gives sign-extended `disp` + `base_val` + `index_val` × d.
- R7: In mode 7 (memory-indirect), in the cycle after acceptance `ptr_rd_req` is high with `ptr_rd_addr = base_val` and `req_ready` is low. Both hold until a cycle in which `ptr_rd_ack` is high. In the next cycle `out_valid` is high with `out_addr` equal to the `ptr_rd_data` sampled with the acknowledge, and `ptr_rd_req` is low.
- R8: Mode 8 (circular) gives `base_val` as the address, with `wb_en` high. Let p = `base_val + d`. If p ≥ `circ_base + circ_len`, then `wb_val = p - circ_len`; otherwise `wb_val = p`.
- R9: Mode 9 (bit-reverse) gives `base_val` plus `index_val` with its low w bits reversed in order and the other bits unchanged. Here w = `brev_bits`, and values above 16 count as 16.
- R10: Mode codes 10 to 15 are ignored. `out_valid` and `wb_en` stay low, and `req_ready` stays high.
- R11: An accepted request in modes 0 to 6, 8 or 9 sets `out_valid` for exactly the next cycle. `wb_en` is high only for modes 4, 5 and 8. Back-to-back requests give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_mode | input | 4 | Addressing mode code |
| base_val | input | 32 | Base / pointer register value |
| index_val | input | 32 | Index register value |
| disp | input | 16 | Signed displacement |
| elem_sz | input | 2 | Element size code (d = 1 << code) |
| circ_base | input | 32 | Circular buffer start |
| circ_len | input | 32 | Circular buffer length in bytes |
| brev_bits | input | 5 | Bit-reverse width |
| out_valid | output | 1 | Result valid |
| out_addr | output | 32 | Effective address |
| wb_en | output | 1 | Write-back value valid |
| wb_val | output | 32 | Updated pointer register value |
| ptr_rd_req | output | 1 | Pointer read request |
| ptr_rd_addr | output | 32 | Pointer read address |
| ptr_rd_ack | input | 1 | Pointer read acknowledge |
| ptr_rd_data | input | 32 | Pointer read data |

## Verification
Displacements are driven both positive and negative, so that a missing sign extension shows up as a wrong upper half. Every element-size code is used at least once, which separates a correct shift from an off-by-one. The circular mode is tried once just below the window end and once at it, which tells a wrap at `>=` from one at `>`. The bit-reverse mode uses widths 3, 4 and an over-range value with nonzero upper index bits, which exposes both a wrong width clamp and bits leaking above the reversed field. The indirect mode holds the acknowledge off for several cycles, and a back-to-back pair checks that results do not merge or drop.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [3:0] {
    AM_DISP    = 4'd0,
    AM_REGIND  = 4'd1,
    AM_INDEXED = 4'd2,
    AM_ABS     = 4'd3,
    AM_POSTINC = 4'd4,
    AM_PREDEC  = 4'd5,
    AM_SCALED  = 4'd6,
    AM_INDIR   = 4'd7,
    AM_CIRC    = 4'd8,
    AM_BREV    = 4'd9
  } amode_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_PTRW = 1'b1
  } agu_state_t;
endpackage

// File: rtl/agu_offset.sv
module agu_offset #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic [DW-1:0] disp_i,
  input  logic [1:0]    sz_i,
  input  logic [AW-1:0] index_i,
  output logic [AW-1:0] disp_ext_o,
  output logic [AW-1:0] step_o,
  output logic [AW-1:0] idx_scaled_o
);
  always_comb begin
    disp_ext_o   = {{(AW-DW){disp_i[DW-1]}}, disp_i};
    step_o       = AW'(1) << sz_i;
    idx_scaled_o = index_i << sz_i;
  end
endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
  parameter int AW       = 32,
  parameter int BREV_MAX = 16
) (
  input  logic [AW-1:0]                     idx_i,
  input  logic [$clog2(BREV_MAX+1)-1:0]     bits_i,
  output logic [AW-1:0]                     rev_o
);
  localparam int BW = $clog2(BREV_MAX+1);
  localparam int SW = $clog2(BREV_MAX);

  logic [BW-1:0] w_eff;
  logic [BW-1:0] src;

  always_comb begin
    w_eff = (bits_i > BW'(BREV_MAX)) ? BW'(BREV_MAX) : bits_i;
    rev_o = idx_i;
    src   = '0;
    for (int i = 0; i < BREV_MAX; i++) begin
      if (BW'(i) < w_eff) begin
        src      = w_eff - BW'(i) - BW'(1);
        rev_o[i] = idx_i[src[SW-1:0]];
      end
    end
  end

  // R9
  always_comb begin
    brev_pop_chk: assert ($countones(rev_o) == $countones(idx_i));
  end
endmodule

// File: rtl/agu_circ.sv
module agu_circ #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] step_i,
  input  logic [AW-1:0] win_base_i,
  input  logic [AW-1:0] win_len_i,
  output logic [AW-1:0] nxt_o,
  output logic          wrap_o
);
  logic [AW-1:0] inc;
  logic [AW-1:0] lim;

  always_comb begin
    inc    = ptr_i + step_i;
    lim    = win_base_i + win_len_i;
    wrap_o = (inc >= lim);
    nxt_o  = wrap_o ? (inc - win_len_i) : inc;
  end
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 16,
  parameter int BREV_MAX = 16,
  localparam int BW      = $clog2(BREV_MAX+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_mode,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [DW-1:0] disp,
  input  logic [1:0]    elem_sz,
  input  logic [AW-1:0] circ_base,
  input  logic [AW-1:0] circ_len,
  input  logic [BW-1:0] brev_bits,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic          wb_en,
  output logic [AW-1:0] wb_val,
  output logic          ptr_rd_req,
  output logic [AW-1:0] ptr_rd_addr,
  input  logic          ptr_rd_ack,
  input  logic [AW-1:0] ptr_rd_data
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [AW-1:0] disp_ext, step, idx_scaled, circ_nxt, brev_idx;
  logic          circ_wrap;

  agu_offset #(.AW(AW), .DW(DW)) u_ofs (
    .disp_i       (disp),
    .sz_i         (elem_sz),
    .index_i      (index_val),
    .disp_ext_o   (disp_ext),
    .step_o       (step),
    .idx_scaled_o (idx_scaled)
  );

  agu_circ #(.AW(AW)) u_circ (
    .ptr_i      (base_val),
    .step_i     (step),
    .win_base_i (circ_base),
    .win_len_i  (circ_len),
    .nxt_o      (circ_nxt),
    .wrap_o     (circ_wrap)
  );

  agu_bitrev #(.AW(AW), .BREV_MAX(BREV_MAX)) u_brev (
    .idx_i  (index_val),
    .bits_i (brev_bits),
    .rev_o  (brev_idx)
  );

  // combinational address calculation
  logic          c_legal, c_indir, c_wbe;
  logic [AW-1:0] c_addr, c_wb;

  always_comb begin
    c_legal = 1'b1;
    c_indir = 1'b0;
    c_wbe   = 1'b0;
    c_addr  = base_val;
    c_wb    = base_val;
    case (req_mode)
      AM_DISP:    c_addr = base_val + disp_ext;
      AM_REGIND:  c_addr = base_val;
      AM_INDEXED: c_addr = base_val + index_val;
      AM_ABS:     c_addr = disp_ext;
      AM_POSTINC: begin
        c_addr = base_val;
        c_wb   = base_val + step;
        c_wbe  = 1'b1;
      end
      AM_PREDEC: begin
        c_addr = base_val - step;
        c_wb   = base_val - step;
        c_wbe  = 1'b1;
      end
      AM_SCALED:  c_addr = disp_ext + base_val + idx_scaled;
      AM_INDIR:   c_indir = 1'b1;
      AM_CIRC: begin
        c_addr = base_val;
        c_wb   = circ_nxt;
        c_wbe  = 1'b1;
      end
      AM_BREV:    c_addr = base_val + brev_idx;
      default:    c_legal = 1'b0;
    endcase
  end

  // control next-state
  agu_state_t    st_q, st_d;
  logic          ov_d, wbe_d, rreq_d;
  logic [AW-1:0] addr_d, wbv_d, raddr_d;
  logic          accept;
  logic          ov_en, addr_en, raddr_en;

  assign req_ready = rst_q && (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready && c_legal;

  always_comb begin
    st_d     = st_q;
    ov_d     = 1'b0;
    wbe_d    = 1'b0;
    rreq_d   = ptr_rd_req;
    addr_d   = out_addr;
    wbv_d    = wb_val;
    raddr_d  = ptr_rd_addr;
    ov_en    = 1'b1;
    addr_en  = 1'b0;
    raddr_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (c_indir) begin
            st_d     = ST_PTRW;
            rreq_d   = 1'b1;
            raddr_d  = base_val;
            raddr_en = 1'b1;
          end else begin
            ov_d    = 1'b1;
            wbe_d   = c_wbe;
            addr_d  = c_addr;
            wbv_d   = c_wb;
            addr_en = 1'b1;
          end
        end
      end
      ST_PTRW: begin
        if (ptr_rd_ack) begin
          st_d    = ST_IDLE;
          rreq_d  = 1'b0;
          ov_d    = 1'b1;
          addr_d  = ptr_rd_data;
          addr_en = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ptr_rd_req <= 1'b0;
    end else if (!rst_q) begin
      st_q       <= ST_IDLE;
      ptr_rd_req <= 1'b0;
    end else begin
      st_q       <= st_d;
      ptr_rd_req <= rreq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
    end else if (ov_en) begin
      out_valid <= ov_d && rst_q;
      wb_en     <= wbe_d && rst_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr <= '0;
      wb_val   <= '0;
    end else if (addr_en) begin
      out_addr <= addr_d;
      wb_val   <= wbv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_rd_addr <= '0;
    end else if (raddr_en) begin
      ptr_rd_addr <= raddr_d;
    end
  end

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (ptr_rd_req && !ptr_rd_ack) |=> (ptr_rd_req && $stable(ptr_rd_addr)));

  // R7
  ptr_done_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (ptr_rd_req && ptr_rd_ack) |=> (out_valid && !ptr_rd_req && out_addr == $past(ptr_rd_data)));

  // R7
  busy_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ptr_rd_req |-> !req_ready);

  // R11
  wb_sub_chk: assert property (@(posedge clk) disable iff (!rst_q)
    wb_en |-> out_valid);

  // R11
  issue_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && req_ready && req_mode != 4'd7 && req_mode <= 4'd9) |=> out_valid);

  // R10
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && req_ready && req_mode >= 4'd10 && !ptr_rd_req) |=> (!out_valid && req_ready));
endmodule

// File: tb/tb_agu_top.sv
module tb_agu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic [31:0] base_val = '0, index_val = '0;
  logic [15:0] disp = '0;
  logic [1:0]  elem_sz = '0;
  logic [31:0] circ_base = '0, circ_len = '0;
  logic [4:0]  brev_bits = '0;
  logic        out_valid, wb_en, ptr_rd_req;
  logic [31:0] out_addr, wb_val, ptr_rd_addr;
  logic        ptr_rd_ack = 1'b0;
  logic [31:0] ptr_rd_data = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  agu_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .base_val(base_val), .index_val(index_val),
    .disp(disp), .elem_sz(elem_sz), .circ_base(circ_base), .circ_len(circ_len),
    .brev_bits(brev_bits), .out_valid(out_valid), .out_addr(out_addr),
    .wb_en(wb_en), .wb_val(wb_val), .ptr_rd_req(ptr_rd_req),
    .ptr_rd_addr(ptr_rd_addr), .ptr_rd_ack(ptr_rd_ack), .ptr_rd_data(ptr_rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] brev_ref(input logic [31:0] v, input int w);
    logic [31:0] r = v;
    int ww = (w > 16) ? 16 : w;
    for (int i = 0; i < ww; i++) r[i] = v[ww-1-i];
    return r;
  endfunction

  // drive one request at a negedge, sample after the next posedge
  task automatic one_req(input logic [3:0] m, input logic [31:0] b, input logic [31:0] x,
                         input logic [15:0] d, input logic [1:0] sz);
    req_mode = m; base_val = b; index_val = x; disp = d; elem_sz = sz;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 out_valid in reset", {31'b0, out_valid}, 32'd0);
    chk("R1 wb_en in reset", {31'b0, wb_en}, 32'd0);
    chk("R1 ptr_rd_req in reset", {31'b0, ptr_rd_req}, 32'd0);
    chk("R1 ready in reset", {31'b0, req_ready}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after one edge", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R1 ready after two edges", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic t_disp();
    one_req(4'd0, 32'h0000_1000, 32'h0, 16'h0064, 2'd0);
    chk("R2 disp positive", out_addr, 32'h0000_1064);
    chk("R11 valid disp", {31'b0, out_valid}, 32'd1);
    chk("R11 no wb disp", {31'b0, wb_en}, 32'd0);
    one_req(4'd0, 32'h0000_1000, 32'h0, 16'hFFF0, 2'd0);
    chk("R2 disp negative", out_addr, 32'h0000_0FF0);
    one_req(4'd1, 32'hDEAD_BEE0, 32'h5, 16'h1234, 2'd0);
    chk("R2 register-indirect", out_addr, 32'hDEAD_BEE0);
  endtask

  task automatic t_idx_abs();
    one_req(4'd2, 32'h0000_2000, 32'h0000_0130, 16'h0, 2'd0);
    chk("R3 indexed", out_addr, 32'h0000_2130);
    one_req(4'd3, 32'h1234_5678, 32'h0, 16'h8001, 2'd0);
    chk("R3 absolute negative", out_addr, sx(16'h8001));
    one_req(4'd3, 32'h1234_5678, 32'h0, 16'h03E9, 2'd0);
    chk("R3 absolute", out_addr, 32'd1001);
  endtask

  task automatic t_postinc();
    for (int s = 0; s < 4; s++) begin
      one_req(4'd4, 32'h0000_0400, 32'h0, 16'h0, 2'(s));
      chk("R4 postinc addr", out_addr, 32'h0000_0400);
      chk("R4 postinc wb", wb_val, 32'h0000_0400 + (32'd1 << s));
      chk("R4 postinc wb_en", {31'b0, wb_en}, 32'd1);
    end
  endtask

  task automatic t_predec();
    one_req(4'd5, 32'h0000_0400, 32'h0, 16'h0, 2'd3);
    chk("R5 predec addr", out_addr, 32'h0000_03F8);
    chk("R5 predec wb", wb_val, 32'h0000_03F8);
    chk("R5 predec wb_en", {31'b0, wb_en}, 32'd1);
  endtask

  task automatic t_scaled();
    one_req(4'd6, 32'h0001_0000, 32'h0000_0005, 16'hFFFC, 2'd2);
    chk("R6 scaled", out_addr, 32'h0001_0000 + 32'd20 - 32'd4);
    one_req(4'd6, 32'h0001_0000, 32'h0000_0003, 16'h0010, 2'd1);
    chk("R6 scaled size 2", out_addr, 32'h0001_0016);
  endtask

  task automatic t_indirect();
    req_mode = 4'd7; base_val = 32'h0000_0940; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 read request", {31'b0, ptr_rd_req}, 32'd1);
    chk("R7 read addr", ptr_rd_addr, 32'h0000_0940);
    chk("R7 busy", {31'b0, req_ready}, 32'd0);
    chk("R7 no early result", {31'b0, out_valid}, 32'd0);
    req_mode = 4'd1; req_valid = 1'b1;     // must be held off
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    chk("R7 request held", {31'b0, ptr_rd_req}, 32'd1);
    chk("R7 no result while waiting", {31'b0, out_valid}, 32'd0);
    ptr_rd_ack = 1'b1; ptr_rd_data = 32'hCAFE_0040;
    @(negedge clk);
    ptr_rd_ack = 1'b0; ptr_rd_data = 32'h0;
    chk("R7 result valid", {31'b0, out_valid}, 32'd1);
    chk("R7 result addr", out_addr, 32'hCAFE_0040);
    chk("R7 request dropped", {31'b0, ptr_rd_req}, 32'd0);
    chk("R7 ready again", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    chk("R11 single pulse", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_circ();
    circ_base = 32'h0000_0100; circ_len = 32'h0000_0020;
    one_req(4'd8, 32'h0000_0118, 32'h0, 16'h0, 2'd2);
    chk("R8 circ addr", out_addr, 32'h0000_0118);
    chk("R8 circ no wrap", wb_val, 32'h0000_011C);
    chk("R8 circ wb_en", {31'b0, wb_en}, 32'd1);
    one_req(4'd8, 32'h0000_011C, 32'h0, 16'h0, 2'd2);
    chk("R8 circ wrap at end", wb_val, 32'h0000_0100);
    one_req(4'd8, 32'h0000_011E, 32'h0, 16'h0, 2'd3);
    chk("R8 circ wrap overshoot", wb_val, 32'h0000_0106);
  endtask

  task automatic t_brev();
    brev_bits = 5'd3;
    one_req(4'd9, 32'h0000_8000, 32'h0000_0003, 16'h0, 2'd0);
    chk("R9 brev 3 bits", out_addr, 32'h0000_8006);
    brev_bits = 5'd4;
    one_req(4'd9, 32'h0000_8000, 32'h0000_00F1, 16'h0, 2'd0);
    chk("R9 brev 4 bits upper kept", out_addr, 32'h0000_8000 + brev_ref(32'h0000_00F1, 4));
    brev_bits = 5'd20;
    one_req(4'd9, 32'h0, 32'h00AB_0001, 16'h0, 2'd0);
    chk("R9 brev clamp 16", out_addr, brev_ref(32'h00AB_0001, 16));
    brev_bits = 5'd0;
  endtask

  task automatic t_reserved();
    for (int m = 10; m < 16; m++) begin
      one_req(4'(m), 32'h0000_5000, 32'h1, 16'h4, 2'd0);
      chk("R10 reserved no valid", {31'b0, out_valid}, 32'd0);
      chk("R10 reserved no wb", {31'b0, wb_en}, 32'd0);
      chk("R10 reserved ready", {31'b0, req_ready}, 32'd1);
    end
  endtask

  task automatic t_stream();
    req_mode = 4'd2; base_val = 32'h100; index_val = 32'h1; req_valid = 1'b1;
    @(negedge clk);
    chk("R11 first of pair", out_addr, 32'h101);
    chk("R11 first valid", {31'b0, out_valid}, 32'd1);
    req_mode = 4'd5; base_val = 32'h200; elem_sz = 2'd1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 second of pair", out_addr, 32'h1FE);
    chk("R11 second valid", {31'b0, out_valid}, 32'd1);
    chk("R11 second wb", {31'b0, wb_en}, 32'd1);
    @(negedge clk);
    chk("R11 pair ends", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_disp();
    t_idx_abs();
    t_postinc();
    t_predec();
    t_scaled();
    t_indirect();
    t_circ();
    t_brev();
    t_reserved();
    t_stream();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule